// File: doc/BRIEF.md
# Multi-Slice Line-Change Timestamping Engine

This block watches a bank of digital input lines, grouped into slices of 32 lines each. It turns every change on an enabled line into a timestamped record. Each record holds four things: the 64-bit free-running tick count taken when the change was seen, the slice number, and the slice's whole 32-bit word both before and after the change. Several lines of one slice that change together therefore share a single record. Software finds the changed lines as the XOR of the two words.

Records wait in a 32-entry FIFO. Software reads them through a small memory-mapped register port. The head registers always show the oldest record, and a pop command discards it. A level interrupt is raised while the FIFO holds at least a programmable number of records. When several slices change in the same cycle, the lowest-numbered slice is stored first. The others wait, one record per cycle, and each keeps the tick count it captured.

Top module: `tse_engine`

## Requirements
- R1: After reset, control reads 0x0000_0100 (engine off, interrupt off, threshold 1), status reads 0, every head register reads 0 and `irq_o` is low.
- R2: A read request returns its data on `rdata_o` in the cycle after the request. The register offsets are: control 0x00, timestamp high 0x04, timestamp low 0x08, source 0x0C, current word 0x10, previous word 0x14, command 0x1C, status 0x20, and the line-enable word of slice s at 0x40 + s*0x20. Control bit 0 is the engine enable, bit 1 is the interrupt enable, and bits [15:8] are the threshold; all other control bits read 0.
- R3: Each input passes through two flops. While the engine is on, a change on any enabled line of a slice creates one record. The record's source register holds the slice number in bits [23:16], and the previous and current words are the slice's full sampled values. Simultaneous changes in one slice share one record.
- R4: Changes while the engine is off, and changes on lines whose enable bit is 0, create no record.
- R5: The timestamp is a 64-bit counter that advances once every TICK_DIV clocks and is read as high and low words. Two changes seen k cycles apart carry timestamps that differ by k/TICK_DIV.
- R6: When several slices change in one cycle, the records enter the FIFO lowest slice first, one per cycle. All of them carry the same timestamp.
- R7: Writing exactly 1 to the command register removes the head record. Any other value, and a pop on an empty FIFO, change nothing.
- R8: When the FIFO is empty, the timestamp, source, current and previous registers read 0.
- R9: Status bits [15:8] hold the number of records in the FIFO.
- R10: The FIFO holds 32 records. A record arriving when the FIFO is full is dropped and sets status bit 0. That bit stays set until software writes 1 to status bit 0.
- R11: `irq_o` is high exactly while the interrupt enable is set and the record count is at least the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lines_i | input | NUM_SLICES*32 | Monitored lines; slice s occupies bits [s*32 +: 32] |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 1 | Level interrupt for the occupancy threshold |

## Verification
The hardest case to reach from the ports is a slice whose record is held pending while a lower slice is served. Its timestamp must survive the wait. The bench reaches it by flipping lines in both slices in the same cycle and comparing the two timestamps read back. Overflow is the other hard case: the bench stops popping and fires 34 single-line changes, so the last two are dropped. It then checks the sticky bit, its write-one-to-clear, and that the 32 records kept are the oldest ones.

// File: rtl/tse_pkg.sv
package tse_pkg;
  localparam int unsigned SLICE_W    = 32;
  localparam int unsigned TS_W       = 64;
  localparam int unsigned SLICE_ID_W = 8;

  localparam int unsigned OFS_CTRL      = 32'h00;
  localparam int unsigned OFS_TS_HI     = 32'h04;
  localparam int unsigned OFS_TS_LO     = 32'h08;
  localparam int unsigned OFS_SRC       = 32'h0C;
  localparam int unsigned OFS_CUR       = 32'h10;
  localparam int unsigned OFS_PREV      = 32'h14;
  localparam int unsigned OFS_CMD       = 32'h1C;
  localparam int unsigned OFS_STAT      = 32'h20;
  localparam int unsigned OFS_EN_BASE   = 32'h40;
  localparam int unsigned OFS_EN_STRIDE = 32'h20;

  typedef struct packed {
    logic [TS_W-1:0]       ts;
    logic [SLICE_ID_W-1:0] slice;
    logic [SLICE_W-1:0]    prev;
    logic [SLICE_W-1:0]    cur;
  } evt_t;
endpackage

// File: rtl/tse_sync.sv
module tse_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] samp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      samp_q <= '0;
    end else begin
      meta_q <= d_i;
      samp_q <= meta_q;
    end
  end

  assign q_o = samp_q;
endmodule

// File: rtl/tse_tick.sv
module tse_tick #(
  parameter int unsigned TICK_DIV = 1,
  parameter int unsigned TS_W     = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [TS_W-1:0] ts_o
);
  logic [TS_W-1:0] ts_q, ts_d;
  logic            step;

  generate
    if (TICK_DIV > 1) begin : g_div
      localparam int unsigned DW = $clog2(TICK_DIV);
      logic [DW-1:0] div_q, div_d;
      always_comb begin
        step  = (div_q == DW'(TICK_DIV - 1));
        div_d = step ? '0 : div_q + 1'b1;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_d;
      end
    end else begin : g_nodiv
      assign step = 1'b1;
    end
  endgenerate

  always_comb begin
    ts_d = ts_q;
    if (step) ts_d = ts_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_q <= '0;
    else         ts_q <= ts_d;
  end

  assign ts_o = ts_q;

  // R5: the counter never moves by more than one tick per clock
  a_r5_ts_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 ((ts_q == $past(ts_q)) || (ts_q == $past(ts_q) + 1'b1)));
endmodule

// File: rtl/tse_slice_track.sv
module tse_slice_track import tse_pkg::*; #(
  parameter int unsigned SLICE_IDX = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SLICE_W-1:0] samp_i,
  input  logic [SLICE_W-1:0] mask_i,
  input  logic               eng_en_i,
  input  logic [TS_W-1:0]    ts_i,
  input  logic               grant_i,
  output logic               pend_o,
  output evt_t               evt_o
);
  logic [SLICE_W-1:0] ref_q, ref_d;
  logic               pend_q, pend_d;
  evt_t               evt_q, evt_d;
  logic               hit;

  assign hit = eng_en_i && (|((samp_i ^ ref_q) & mask_i));

  always_comb begin
    ref_d  = ref_q;
    pend_d = pend_q;
    evt_d  = evt_q;
    if (pend_q) begin
      if (grant_i) pend_d = 1'b0;
    end else begin
      ref_d = samp_i;
      if (hit) begin
        pend_d      = 1'b1;
        evt_d.ts    = ts_i;
        evt_d.slice = SLICE_ID_W'(SLICE_IDX);
        evt_d.prev  = ref_q;
        evt_d.cur   = samp_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= '0;
      pend_q <= 1'b0;
      evt_q  <= '0;
    end else begin
      ref_q  <= ref_d;
      pend_q <= pend_d;
      evt_q  <= evt_d;
    end
  end

  assign pend_o = pend_q;
  assign evt_o  = evt_q;

  // R6: a waiting record keeps its captured contents until granted
  a_r6_hold_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !grant_i) |=> (pend_q && $stable(evt_q)));
  // R4: with the engine off, no new record is raised
  a_r4_no_capture_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eng_en_i && !pend_q) |=> !pend_q);
endmodule

// File: rtl/tse_arb.sv
module tse_arb #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
      end
    end
  end

  // R6: at most one slice served per cycle
  a_r6_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R6: some slice is served whenever one waits
  a_r6_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> (|gnt_o));
  // R6: no waiting slice below the served one
  a_r6_lowest_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o - 1'b1) & req_i) == '0);
endmodule

// File: rtl/tse_fifo.sv
module tse_fifo #(
  parameter int unsigned W     = 136,
  parameter int unsigned DEPTH = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic [W-1:0]               din_i,
  input  logic                       pop_i,
  output logic [W-1:0]               dout_o,
  output logic [$clog2(DEPTH+1)-1:0] cnt_o,
  output logic                       full_o,
  output logic                       empty_o
);
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (do_push) wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (do_pop)  rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr_q] <= din_i;
  end

  assign dout_o = mem[rptr_q];
  assign cnt_o  = cnt_q;

  // R10: occupancy never passes the depth
  a_r10_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  // R10: a push into a full FIFO is lost
  a_r10_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> (cnt_q == CNT_W'(DEPTH)));
  // R7: a lone pop removes exactly one record
  a_r7_pop_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !empty_o && !push_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/tse_engine.sv
module tse_engine import tse_pkg::*; #(
  parameter int unsigned NUM_SLICES = 2,
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned TICK_DIV   = 1,
  parameter int unsigned ADDR_W     = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_SLICES*SLICE_W-1:0] lines_i,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [31:0]                   wdata_i,
  output logic [31:0]                   rdata_o,
  output logic                          irq_o
);
  localparam int unsigned LINES = NUM_SLICES * SLICE_W;
  localparam int unsigned EVT_W = $bits(evt_t);
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [LINES-1:0]   samp;
  logic [TS_W-1:0]    ts_now;
  logic [NUM_SLICES-1:0] pend, gnt;
  evt_t               evt_arr [NUM_SLICES];
  evt_t               evt_sel, head;
  logic [EVT_W-1:0]   fifo_dout;
  logic [CNT_W-1:0]   fifo_cnt;
  logic               fifo_full, fifo_empty;

  logic               en_q, en_d, ie_q, ie_d, ovf_q, ovf_d;
  logic [7:0]         thr_q, thr_d;
  logic [SLICE_W-1:0] mask_q [NUM_SLICES];
  logic [SLICE_W-1:0] mask_d [NUM_SLICES];
  logic [31:0]        rdata_q, rdata_d, rd_val;

  logic               wr, rd_req, wr_ctrl, wr_cmd, wr_stat, pop, drop, any_gnt;
  logic [NUM_SLICES-1:0] wr_mask;

  tse_sync #(.W(LINES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(lines_i), .q_o(samp)
  );

  tse_tick #(.TICK_DIV(TICK_DIV), .TS_W(TS_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .ts_o(ts_now)
  );

  generate
    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
      tse_slice_track #(.SLICE_IDX(s)) u_track (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .samp_i  (samp[s*SLICE_W +: SLICE_W]),
        .mask_i  (mask_q[s]),
        .eng_en_i(en_q),
        .ts_i    (ts_now),
        .grant_i (gnt[s]),
        .pend_o  (pend[s]),
        .evt_o   (evt_arr[s])
      );
    end
  endgenerate

  tse_arb #(.N(NUM_SLICES)) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(pend), .gnt_o(gnt)
  );

  always_comb begin
    evt_sel = '0;
    for (int s = 0; s < NUM_SLICES; s++) begin
      if (gnt[s]) evt_sel = evt_sel | evt_arr[s];
    end
  end

  assign any_gnt = |gnt;
  assign drop    = any_gnt && fifo_full;

  tse_fifo #(.W(EVT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (any_gnt),
    .din_i  (evt_sel),
    .pop_i  (pop),
    .dout_o (fifo_dout),
    .cnt_o  (fifo_cnt),
    .full_o (fifo_full),
    .empty_o(fifo_empty)
  );

  assign head = fifo_empty ? '0 : evt_t'(fifo_dout);

  // register port decode
  always_comb begin
    wr      = req_i && we_i;
    rd_req  = req_i && !we_i;
    wr_ctrl = wr && (addr_i == ADDR_W'(OFS_CTRL));
    wr_cmd  = wr && (addr_i == ADDR_W'(OFS_CMD));
    wr_stat = wr && (addr_i == ADDR_W'(OFS_STAT));
    for (int s = 0; s < NUM_SLICES; s++) begin
      wr_mask[s] = wr && (addr_i == ADDR_W'(OFS_EN_BASE + s * OFS_EN_STRIDE));
    end
    pop = wr_cmd && (wdata_i == 32'd1);
  end

  // next state of the control and status state
  always_comb begin
    en_d  = en_q;
    ie_d  = ie_q;
    thr_d = thr_q;
    ovf_d = ovf_q;
    if (wr_ctrl) begin
      en_d  = wdata_i[0];
      ie_d  = wdata_i[1];
      thr_d = wdata_i[15:8];
    end
    if (wr_stat && wdata_i[0]) ovf_d = 1'b0;
    if (drop) ovf_d = 1'b1;
    for (int s = 0; s < NUM_SLICES; s++) begin
      mask_d[s] = wr_mask[s] ? wdata_i : mask_q[s];
    end
  end

  // read mux
  always_comb begin
    rd_val = '0;
    if (addr_i == ADDR_W'(OFS_CTRL))  rd_val = {16'b0, thr_q, 6'b0, ie_q, en_q};
    if (addr_i == ADDR_W'(OFS_TS_HI)) rd_val = head.ts[63:32];
    if (addr_i == ADDR_W'(OFS_TS_LO)) rd_val = head.ts[31:0];
    if (addr_i == ADDR_W'(OFS_SRC))   rd_val = {8'b0, head.slice, 16'b0};
    if (addr_i == ADDR_W'(OFS_CUR))   rd_val = head.cur;
    if (addr_i == ADDR_W'(OFS_PREV))  rd_val = head.prev;
    if (addr_i == ADDR_W'(OFS_STAT))  rd_val = {16'b0, 8'(fifo_cnt), 7'b0, ovf_q};
    for (int s = 0; s < NUM_SLICES; s++) begin
      if (addr_i == ADDR_W'(OFS_EN_BASE + s * OFS_EN_STRIDE)) rd_val = mask_q[s];
    end
    rdata_d = rd_req ? rd_val : rdata_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      ie_q    <= 1'b0;
      thr_q   <= 8'd1;
      ovf_q   <= 1'b0;
      rdata_q <= '0;
      for (int s = 0; s < NUM_SLICES; s++) mask_q[s] <= '0;
    end else begin
      en_q    <= en_d;
      ie_q    <= ie_d;
      thr_q   <= thr_d;
      ovf_q   <= ovf_d;
      rdata_q <= rdata_d;
      for (int s = 0; s < NUM_SLICES; s++) mask_q[s] <= mask_d[s];
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = ie_q && (32'(fifo_cnt) >= 32'(thr_q));

  // R11: the interrupt needs its enable
  a_r11_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_q |-> !irq_o);
  // R11: an empty FIFO keeps a non-zero threshold unmet
  a_r11_irq_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_empty && thr_q != 8'd0) |-> !irq_o);
  // R10: overflow flag stays until cleared by software
  a_r10_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !(wr_stat && wdata_i[0])) |=> ovf_q);
  // R8: head words read zero while nothing is queued
  a_r8_empty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && fifo_empty && addr_i == ADDR_W'(OFS_TS_LO)) |=> (rdata_o == 32'd0));
endmodule

// File: tb/tse_engine_test.sv
module tse_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h00, A_TSH = 8'h04, A_TSL = 8'h08, A_SRC = 8'h0C,
                         A_CUR = 8'h10, A_PREV = 8'h14, A_CMD = 8'h1C, A_STAT = 8'h20,
                         A_EN0 = 8'h40, A_EN1 = 8'h60;

  logic        clk, rst_n, req, we, irq;
  logic [63:0] lines;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;

  logic [31:0] bref [2];
  logic [31:0] ben  [2];
  logic        beng;
  logic [7:0]  q_sl [$];
  logic [31:0] q_prev [$];
  logic [31:0] q_cur [$];

  tse_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .lines_i(lines), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired act=%0d exp<=150000", cyc);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  // expected record for a change: enabled changed bits while engine on
  function automatic logic want_rec(input logic [31:0] oldv, input logic [31:0] newv,
                                    input logic [31:0] mask, input logic eng);
    return eng && (((oldv ^ newv) & mask) != 32'd0);
  endfunction

  task automatic apply(input logic [31:0] n0, input logic [31:0] n1);
    @(negedge clk);
    if (want_rec(bref[0], n0, ben[0], beng) && q_sl.size() < 32) begin
      q_sl.push_back(8'd0); q_prev.push_back(bref[0]); q_cur.push_back(n0);
    end
    if (want_rec(bref[1], n1, ben[1], beng) && q_sl.size() < 32) begin
      q_sl.push_back(8'd1); q_prev.push_back(bref[1]); q_cur.push_back(n1);
    end
    bref[0] = n0; bref[1] = n1;
    lines = {n1, n0};
    idle(8);
  endtask

  task automatic drain(input string tag);
    logic [31:0] v;
    while (q_sl.size() != 0) begin
      rd(A_SRC, v);  chk({tag, " R3 source slice"}, v, {8'd0, q_sl[0], 16'd0});
      rd(A_PREV, v); chk({tag, " R3 previous word"}, v, q_prev[0]);
      rd(A_CUR, v);  chk({tag, " R3 current word"}, v, q_cur[0]);
      wr(A_CMD, 32'd1);
      void'(q_sl.pop_front()); void'(q_prev.pop_front()); void'(q_cur.pop_front());
    end
    rd(A_STAT, v); chk({tag, " R9 status after drain"}, v, 32'd0);
  endtask

  initial begin
    logic [31:0] v, hi, lo;
    logic [63:0] ta, tb2;
    void'($urandom(32'd4711));
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0; lines = '0;
    bref[0] = '0; bref[1] = '0; ben[0] = '0; ben[1] = '0; beng = 1'b0;
    idle(5);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(A_CTRL, v); chk("R1 control reset", v, 32'h0000_0100);
    rd(A_STAT, v); chk("R1 status reset", v, 32'd0);
    chk("R1 irq reset", irq, 1'b0);
    rd(A_TSH, v);  chk("R1 ts high reset", v, 32'd0);
    rd(A_SRC, v);  chk("R1 source reset", v, 32'd0);

    // R2 control field layout
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R2 control readback", v, 32'h0000_FF03);
    wr(A_CTRL, 32'd0);

    // R4 engine off
    wr(A_EN0, 32'hFFFF_FFFF); wr(A_EN1, 32'hFFFF_FFFF);
    ben[0] = 32'hFFFF_FFFF; ben[1] = 32'hFFFF_FFFF;
    rd(A_EN1, v); chk("R2 enable word slice 1", v, 32'hFFFF_FFFF);
    apply(32'h0000_00FF, 32'd0);
    rd(A_STAT, v); chk("R4 no record while engine off", v, 32'd0);

    wr(A_CTRL, 32'h0000_0103); beng = 1'b1;

    // R4 disabled line
    wr(A_EN0, 32'hFFFF_FFFE); ben[0] = 32'hFFFF_FFFE;
    apply(bref[0] ^ 32'h1, bref[1]);
    rd(A_STAT, v); chk("R4 no record on disabled line", v, 32'd0);

    // R3 two lines in one record, R9, R11
    apply(bref[0] ^ 32'h28, bref[1]);
    rd(A_STAT, v); chk("R9 one record counted", v, 32'h0000_0100);
    chk("R11 irq at threshold 1", irq, 1'b1);
    wr(A_CTRL, 32'h0000_0203);
    idle(1);
    chk("R11 irq below threshold 2", irq, 1'b0);
    wr(A_CTRL, 32'h0000_0103);
    rd(A_PREV, hi); rd(A_CUR, lo);
    chk("R3 changed lines are prev xor cur", hi ^ lo, 32'h28);

    // R7 pop command
    wr(A_CMD, 32'd2);
    rd(A_STAT, v); chk("R7 command value 2 ignored", v, 32'h0000_0100);
    wr(A_CMD, 32'd1);
    void'(q_sl.pop_front()); void'(q_prev.pop_front()); void'(q_cur.pop_front());
    rd(A_STAT, v); chk("R7 pop removes head", v, 32'd0);
    wr(A_CMD, 32'd1);
    rd(A_STAT, v); chk("R7 pop on empty ignored", v, 32'd0);

    // R8 empty head registers
    rd(A_TSL, v);  chk("R8 ts low empty", v, 32'd0);
    rd(A_CUR, v);  chk("R8 current empty", v, 32'd0);
    rd(A_PREV, v); chk("R8 previous empty", v, 32'd0);

    // R5 timestamp distance
    @(negedge clk); bref[0] = bref[0] ^ 32'h2; lines[31:0] = bref[0];
    idle(7);        bref[0] = bref[0] ^ 32'h4; lines[31:0] = bref[0];
    idle(8);
    rd(A_TSH, hi); rd(A_TSL, lo); ta = {hi, lo};
    wr(A_CMD, 32'd1);
    rd(A_TSH, hi); rd(A_TSL, lo); tb2 = {hi, lo};
    wr(A_CMD, 32'd1);
    chk("R5 timestamps 7 cycles apart", tb2 - ta, 64'd7);
    chk("R5 timestamp non-zero", (ta != 64'd0), 1'b1);

    // R6 simultaneous slices
    @(negedge clk);
    bref[0] = bref[0] ^ 32'h100; bref[1] = bref[1] ^ 32'h8000_0000;
    lines = {bref[1], bref[0]};
    idle(8);
    rd(A_STAT, v); chk("R6 two records queued", v, 32'h0000_0200);
    rd(A_SRC, v);  chk("R6 lower slice first", v, 32'h0000_0000);
    rd(A_TSH, hi); rd(A_TSL, lo); ta = {hi, lo};
    wr(A_CMD, 32'd1);
    rd(A_SRC, v);  chk("R6 higher slice second", v, 32'h0001_0000);
    rd(A_CUR, v);  chk("R6 slice 1 current word", v, bref[1]);
    rd(A_TSH, hi); rd(A_TSL, lo); tb2 = {hi, lo};
    chk("R6 held record keeps timestamp", tb2, ta);
    wr(A_CMD, 32'd1);

    // R3/R6 constrained random
    ben[0] = $urandom; ben[1] = $urandom;
    wr(A_EN0, ben[0]); wr(A_EN1, ben[1]);
    for (int i = 0; i < 60; i++) begin
      logic [31:0] n0, n1;
      n0 = ($urandom % 3 == 0) ? bref[0] : bref[0] ^ $urandom;
      n1 = ($urandom % 3 == 0) ? bref[1] : bref[1] ^ $urandom;
      apply(n0, n1);
      chk("R11 irq follows occupancy", irq, (q_sl.size() >= 1));
      if (q_sl.size() >= 5) drain("random");
    end
    drain("random final");

    // R10 overflow
    wr(A_EN0, 32'hFFFF_FFFF); ben[0] = 32'hFFFF_FFFF;
    for (int i = 0; i < 34; i++) apply(bref[0] ^ 32'h1, bref[1]);
    rd(A_STAT, v); chk("R10 full with overflow flag", v, 32'h0000_2001);
    wr(A_STAT, 32'd0);
    rd(A_STAT, v); chk("R10 writing 0 keeps flag", v, 32'h0000_2001);
    wr(A_STAT, 32'd1);
    rd(A_STAT, v); chk("R10 write one clears flag", v, 32'h0000_2000);
    drain("R10 oldest kept");

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule